// File: doc/BRIEF.md
# CAN Message Buffer Frame Formatter

This block sits between a CAN controller's frame logic and its byte-wide message buffer window. The window holds thirteen slots, and each slot carries one byte. On the transmit side the block takes a parallel frame descriptor and emits one slot write per cycle. The descriptor holds a 29-bit identifier, a format flag, a remote flag, a length code and eight data bytes. The block writes the identifier slots first, then the data slots, and writes the frame-info slot last. This ordering lets a downstream consumer treat the info write as the commit of a complete frame.

On the receive side the block accepts slot writes from a host or from the receive path, in any order. It rebuilds the identifier and places the data bytes. It raises a frame-valid flag once every slot that the frame's format needs has arrived. A release strobe frees the held frame. While the controller is in its reset mode, writes to slots 0 and 1 load the 32-bit acceptance code and acceptance mask instead. A mask of all ones with a code of zero accepts every frame, and this is the state the block takes at reset.

Top module: `can_msgbuf_fmt`

## Requirements
- R1: After reset, `acc_code` is 0, `acc_mask` is 32'hFFFFFFFF, `wr_en` is 0 and `rx_valid` is 0.
- R2: A `tx_start` pulse, sampled while the block is idle and not in reset mode, starts a transmit burst. The first slot write appears in the cycle after the edge that samples the pulse. One write follows per cycle with no gap. The writes cover the identifier slots in ascending order, then the data slots in ascending order, and end with slot 0.
- R3: The slot 0 byte is {format, remote, 2'b00, dlc[3:0]}. Bit 7 set means extended format and bit 6 set means remote frame. The length code is carried unclamped.
- R4: A standard frame places id[10:3] in slot 1 and {id[2:0],5'b0} in slot 2. Its data byte k (`data[8k+7:8k]`) goes in slot 3+k.
- R5: An extended frame places id[28:21] in slot 1, id[20:13] in slot 2, id[12:5] in slot 3 and {id[4:0],3'b0} in slot 4. Its data byte k goes in slot 5+k.
- R6: A remote frame transfers no data slots. On receive, such a frame becomes valid without any data slots, and its data output reads zero.
- R7: A length code above 8 moves exactly 8 data bytes, on both transmit and receive.
- R8: `rx_valid` rises only once slot 0 and every identifier and data slot that slot 0 implies have been written since the last release, whatever the order of the writes. While `rx_valid` is low, all receive descriptor outputs read zero. Data bytes beyond the length read zero.
- R9: `rx_release` clears `rx_valid` in the next cycle. A slot write in the same cycle as the release is kept as the first slot of the next frame.
- R10: While a frame is valid and not released, slot writes leave the receive outputs unchanged.
- R11: In reset mode, a write to slot 0 loads `acc_code` and a write to slot 1 loads `acc_mask`, using all 32 bits. No slot write reaches the receive buffer, and `tx_start` is ignored. Outside reset mode the acceptance registers hold their value.
- R12: A `tx_start` that arrives during a burst is ignored, and the burst in progress completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reset_mode | input | 1 | Controller reset mode; redirects slots 0/1 to the acceptance registers |
| tx_start | input | 1 | Start packing the transmit descriptor |
| tx_ext | input | 1 | Transmit extended format |
| tx_rtr | input | 1 | Transmit remote frame |
| tx_id | input | 29 | Transmit identifier (standard uses [10:0]) |
| tx_dlc | input | 4 | Transmit length code |
| tx_data | input | 64 | Transmit data, byte k at [8k+7:8k] |
| tx_busy | output | 1 | Burst in progress |
| wr_en | output | 1 | Slot write strobe |
| wr_slot | output | 4 | Slot index of the write |
| wr_byte | output | 8 | Slot byte of the write |
| host_we | input | 1 | Slot write into the receive buffer |
| host_slot | input | 4 | Slot index (0..12) |
| host_wdata | input | 32 | Write data; the buffer keeps [7:0] |
| rx_release | input | 1 | Release the held receive frame |
| rx_valid | output | 1 | Receive descriptor complete |
| rx_ext | output | 1 | Received extended format |
| rx_rtr | output | 1 | Received remote frame |
| rx_id | output | 29 | Received identifier |
| rx_dlc | output | 4 | Received length code |
| rx_data | output | 64 | Received data, byte k at [8k+7:8k] |
| acc_code | output | 32 | Acceptance code |
| acc_mask | output | 32 | Acceptance mask |

## Verification
The release of a held frame and the capture of a new slot write can fall in the same cycle. The bench provokes this by holding a valid frame and then asserting `rx_release` together with a slot 0 write that describes a short remote frame. It then writes only the two identifier slots. The outcome is judged on `rx_valid` and the new descriptor: they appear only if the simultaneous write survived the release. A second overlap, a new `tx_start` during a running burst, is judged by comparing the full write sequence against the first frame's expected sequence.

// File: rtl/can_msgbuf_fmt.sv
module can_msgbuf_fmt #(
  parameter int SLOTS = 13
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reset_mode,
  input  logic        tx_start,
  input  logic        tx_ext,
  input  logic        tx_rtr,
  input  logic [28:0] tx_id,
  input  logic [3:0]  tx_dlc,
  input  logic [63:0] tx_data,
  output logic        tx_busy,
  output logic        wr_en,
  output logic [3:0]  wr_slot,
  output logic [7:0]  wr_byte,
  input  logic        host_we,
  input  logic [3:0]  host_slot,
  input  logic [31:0] host_wdata,
  input  logic        rx_release,
  output logic        rx_valid,
  output logic        rx_ext,
  output logic        rx_rtr,
  output logic [28:0] rx_id,
  output logic [3:0]  rx_dlc,
  output logic [63:0] rx_data,
  output logic [31:0] acc_code,
  output logic [31:0] acc_mask
);

  localparam logic [3:0] STD_BASE = 4'd3;
  localparam logic [3:0] EXT_BASE = 4'd5;
  localparam logic [3:0] MAX_DATA = 4'd8;

  // transmit packer
  logic        t_act, t_ext, t_rtr;
  logic [28:0] t_id;
  logic [3:0]  t_dlc, t_slot;
  logic [63:0] t_data;

  wire [3:0] t_n    = t_rtr ? 4'd0 : ((t_dlc > MAX_DATA) ? MAX_DATA : t_dlc);
  wire [3:0] t_base = t_ext ? EXT_BASE : STD_BASE;
  wire [3:0] t_last = t_base + t_n - 4'd1;
  wire [3:0] t_di   = t_slot - t_base;
  wire [7:0] t_dbyte = t_data[{t_di[2:0], 3'b000} +: 8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_act  <= 1'b0;
      t_slot <= '0;
      t_ext  <= 1'b0;
      t_rtr  <= 1'b0;
      t_id   <= '0;
      t_dlc  <= '0;
      t_data <= '0;
    end else if (!t_act) begin
      if (tx_start && !reset_mode) begin
        t_act  <= 1'b1;
        t_slot <= 4'd1;
        t_ext  <= tx_ext;
        t_rtr  <= tx_rtr;
        t_id   <= tx_id;
        t_dlc  <= tx_dlc;
        t_data <= tx_data;
      end
    end else if (t_slot == 4'd0) begin
      t_act <= 1'b0;
    end else if (t_slot == t_last) begin
      t_slot <= 4'd0;
    end else begin
      t_slot <= t_slot + 4'd1;
    end
  end

  assign tx_busy = t_act;
  assign wr_en   = t_act;
  assign wr_slot = t_slot;

  always_comb begin
    case (t_slot)
      4'd0:    wr_byte = {t_ext, t_rtr, 2'b00, t_dlc};
      4'd1:    wr_byte = t_ext ? t_id[28:21] : t_id[10:3];
      4'd2:    wr_byte = t_ext ? t_id[20:13] : {t_id[2:0], 5'b00000};
      4'd3:    wr_byte = t_ext ? t_id[12:5]  : t_dbyte;
      4'd4:    wr_byte = t_ext ? {t_id[4:0], 3'b000} : t_dbyte;
      default: wr_byte = t_dbyte;
    endcase
  end

  // receive unpacker and acceptance registers
  logic [7:0]       rb [SLOTS];
  logic [SLOTS-1:0] cap;

  wire       r_ext  = rb[0][7];
  wire       r_rtr  = rb[0][6];
  wire [3:0] r_dlc  = rb[0][3:0];
  wire [3:0] r_n    = r_rtr ? 4'd0 : ((r_dlc > MAX_DATA) ? MAX_DATA : r_dlc);
  wire [3:0] r_base = r_ext ? EXT_BASE : STD_BASE;
  wire [SLOTS:0]   need_w = ({{SLOTS{1'b0}}, 1'b1} << (r_base + r_n)) - 1'b1;
  wire [SLOTS-1:0] need   = need_w[SLOTS-1:0];
  wire complete = cap[0] && ((cap & need) == need);
  wire take = host_we && !reset_mode && (host_slot < 4'(SLOTS)) && (!complete || rx_release);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap      <= '0;
      acc_code <= '0;
      acc_mask <= '1;
      for (int i = 0; i < SLOTS; i++) rb[i] <= '0;
    end else begin
      if (reset_mode && host_we && host_slot == 4'd0) acc_code <= host_wdata;
      if (reset_mode && host_we && host_slot == 4'd1) acc_mask <= host_wdata;
      if (rx_release) cap <= '0;
      if (take) begin
        rb[host_slot]  <= host_wdata[7:0];
        cap[host_slot] <= 1'b1;
      end
    end
  end

  assign rx_valid = complete;
  assign rx_ext   = complete & r_ext;
  assign rx_rtr   = complete & r_rtr;
  assign rx_dlc   = complete ? r_dlc : 4'd0;
  assign rx_id    = !complete ? 29'd0 :
                    r_ext ? {rb[1], rb[2], rb[3], rb[4][7:3]} :
                            {18'd0, rb[1], rb[2][7:5]};

  for (genvar g = 0; g < 8; g++) begin : g_rxd
    wire [3:0] src = r_base + 4'(g);
    assign rx_data[8*g +: 8] = (complete && (4'(g) < r_n)) ? rb[src] : 8'h00;
  end

endmodule

// File: rtl/can_msgbuf_fmt_chk.sv
module can_msgbuf_fmt_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reset_mode,
  input logic        wr_en,
  input logic [3:0]  wr_slot,
  input logic        rx_release,
  input logic        rx_valid,
  input logic        rx_ext,
  input logic [28:0] rx_id,
  input logic [31:0] acc_code,
  input logic [31:0] acc_mask
);

  assert_slot_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wr_slot < 4'd13);

  assert_info_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_slot == 4'd0) |=> !wr_en);

  assert_no_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_slot != 4'd0) |=> wr_en);

  assert_std_id_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ext) |-> rx_id[28:11] == 18'd0);

  assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_release |=> !rx_valid);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_release) |=> rx_valid);

  assert_acc_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !reset_mode |=> ($stable(acc_code) && $stable(acc_mask)));

  assert_no_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (reset_mode && !wr_en) |=> !wr_en);

endmodule

bind can_msgbuf_fmt can_msgbuf_fmt_chk chk_i (
  .clk(clk), .rst_n(rst_n), .reset_mode(reset_mode), .wr_en(wr_en),
  .wr_slot(wr_slot), .rx_release(rx_release), .rx_valid(rx_valid),
  .rx_ext(rx_ext), .rx_id(rx_id), .acc_code(acc_code), .acc_mask(acc_mask)
);

// File: tb/can_msgbuf_fmt_tb_top.sv
`timescale 1ns/1ps
module can_msgbuf_fmt_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reset_mode = 1'b0;
  logic tx_start = 1'b0, tx_ext = 1'b0, tx_rtr = 1'b0;
  logic [28:0] tx_id = '0;
  logic [3:0]  tx_dlc = '0;
  logic [63:0] tx_data = '0;
  logic tx_busy, wr_en;
  logic [3:0] wr_slot;
  logic [7:0] wr_byte;
  logic host_we = 1'b0;
  logic [3:0] host_slot = '0;
  logic [31:0] host_wdata = '0;
  logic rx_release = 1'b0;
  logic rx_valid, rx_ext, rx_rtr;
  logic [28:0] rx_id;
  logic [3:0] rx_dlc;
  logic [63:0] rx_data;
  logic [31:0] acc_code, acc_mask;

  always #2.5 clk = ~clk;

  can_msgbuf_fmt dut_i (.*);

  int checks = 0, fails = 0;
  int cyc = 0;
  logic [3:0] got_slot [16];
  logic [7:0] got_byte [16];
  int got_n;

  // {ext, rtr, dlc, id, data}
  localparam logic [98:0] VEC [6] = '{
    {1'b0, 1'b0, 4'd8,  29'h000007A5, 64'h8877665544332211},
    {1'b1, 1'b0, 4'd8,  29'h1ABCDEF5, 64'h0123456789ABCDEF},
    {1'b0, 1'b0, 4'd0,  29'h00000001, 64'hFFFFFFFFFFFFFFFF},
    {1'b1, 1'b1, 4'd4,  29'h1FFFFFFF, 64'hDEADBEEFCAFEF00D},
    {1'b0, 1'b0, 4'd3,  29'h00000400, 64'h55443322110000CC},
    {1'b1, 1'b0, 4'd12, 29'h00000001, 64'hA1B2C3D4E5F60718}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int ndata(input logic rtr, input logic [3:0] dlc);
    return rtr ? 0 : ((dlc > 8) ? 8 : int'(dlc));
  endfunction

  function automatic logic [7:0] exp_byte(input logic ext, input logic rtr, input logic [3:0] dlc,
                                          input logic [28:0] id, input logic [63:0] d, input int s);
    int base = ext ? 5 : 3;
    if (s == 0) return {ext, rtr, 2'b00, dlc};
    if (ext) begin
      if (s == 1) return id[28:21];
      if (s == 2) return id[20:13];
      if (s == 3) return id[12:5];
      if (s == 4) return {id[4:0], 3'b000};
    end else begin
      if (s == 1) return id[10:3];
      if (s == 2) return {id[2:0], 5'b00000};
    end
    return d[8*(s-base) +: 8];
  endfunction

  task automatic run_tx(input logic e, input logic r, input logic [3:0] l, input logic [28:0] i,
                        input logic [63:0] d, input bit inject);
    @(negedge clk);
    tx_start = 1'b1; tx_ext = e; tx_rtr = r; tx_dlc = l; tx_id = i; tx_data = d;
    @(negedge clk);
    tx_start = 1'b0;
    got_n = 0;
    while (wr_en && got_n < 16) begin
      got_slot[got_n] = wr_slot;
      got_byte[got_n] = wr_byte;
      got_n++;
      if (inject && got_n == 2) begin
        tx_start = 1'b1; tx_ext = ~e; tx_rtr = 1'b0; tx_dlc = 4'd1; tx_id = ~i; tx_data = ~d;
      end else tx_start = 1'b0;
      @(negedge clk);
    end
    tx_start = 1'b0;
  endtask

  task automatic check_tx(input logic e, input logic r, input logic [3:0] l, input logic [28:0] i,
                          input logic [63:0] d, input string req);
    int base = e ? 5 : 3;
    int n = ndata(r, l);
    int cnt = base + n;
    chk(got_n == cnt, {req, " R2 write count"}, 64'(got_n), 64'(cnt));
    for (int k = 0; k < cnt && k < got_n; k++) begin
      int s = (k == cnt - 1) ? 0 : k + 1;
      chk(got_slot[k] == 4'(s), {req, " R2 slot order"}, 64'(got_slot[k]), 64'(s));
      chk(got_byte[k] == exp_byte(e, r, l, i, d, s),
          (s == 0) ? "R3 info byte" : (e ? "R5 ext slot byte" : "R4 std slot byte"),
          64'(got_byte[k]), 64'(exp_byte(e, r, l, i, d, s)));
    end
  endtask

  task automatic hw(input logic [3:0] s, input logic [31:0] v, input logic rel);
    @(negedge clk);
    host_we = 1'b1; host_slot = s; host_wdata = v; rx_release = rel;
    @(negedge clk);
    host_we = 1'b0; rx_release = 1'b0;
  endtask

  task automatic release_frame();
    @(negedge clk);
    rx_release = 1'b1;
    @(negedge clk);
    rx_release = 1'b0;
    chk(!rx_valid, "R9 release clears valid", 64'(rx_valid), 64'd0);
  endtask

  initial begin
    while (cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    fails++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=<100000", cyc);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(acc_code == 32'h0, "R1 acc_code reset", 64'(acc_code), 64'h0);
    chk(acc_mask == 32'hFFFFFFFF, "R1 acc_mask reset", 64'(acc_mask), 64'hFFFFFFFF);
    chk(!wr_en && !rx_valid, "R1 idle outputs", {wr_en, rx_valid}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rx_data == 64'd0 && rx_id == 29'd0, "R8 zero descriptor when invalid", rx_data, 64'd0);

    // table walk: transmit, then loop the bytes back into the receiver
    for (int v = 0; v < 6; v++) begin
      logic e, r; logic [3:0] l; logic [28:0] i; logic [63:0] d;
      logic [63:0] ed; logic [28:0] eid;
      int n;
      {e, r, l, i, d} = VEC[v];
      n = ndata(r, l);
      run_tx(e, r, l, i, d, 1'b0);
      check_tx(e, r, l, i, d, (r ? "R6" : ((l > 8) ? "R7" : "table")));
      for (int k = 0; k < got_n; k++) begin
        hw(got_slot[k], {24'hABCDEF, got_byte[k]}, 1'b0);
        if (k < got_n - 1)
          chk(!rx_valid, "R8 valid before last slot", 64'(rx_valid), 64'd0);
      end
      ed = '0;
      for (int b = 0; b < n; b++) ed[8*b +: 8] = d[8*b +: 8];
      eid = e ? i : {18'd0, i[10:0]};
      chk(rx_valid, "R8 valid after all slots", 64'(rx_valid), 64'd1);
      chk(rx_id == eid, e ? "R5 rx id" : "R4 rx id", 64'(rx_id), 64'(eid));
      chk(rx_ext == e && rx_rtr == r && rx_dlc == l, "R3 rx flags and dlc",
          {rx_ext, rx_rtr, rx_dlc}, {e, r, l});
      chk(rx_data == ed, r ? "R6 remote data zero" : ((l > 8) ? "R7 rx clamp" : "R8 rx data"), rx_data, ed);
      release_frame();
    end

    // R12: start during a burst is ignored
    begin
      logic e, r; logic [3:0] l; logic [28:0] i; logic [63:0] d;
      {e, r, l, i, d} = VEC[0];
      run_tx(e, r, l, i, d, 1'b1);
      check_tx(e, r, l, i, d, "R12");
      repeat (2) @(negedge clk);
      chk(!wr_en, "R12 no second burst", 64'(wr_en), 64'd0);
    end

    // R8: out of order capture, extended with one data byte
    hw(4'd5, 32'h5A, 1'b0);
    hw(4'd0, 32'h81, 1'b0);
    hw(4'd1, 32'h12, 1'b0);
    hw(4'd2, 32'h34, 1'b0);
    hw(4'd3, 32'h56, 1'b0);
    chk(!rx_valid, "R8 not valid with slot 4 missing", 64'(rx_valid), 64'd0);
    hw(4'd4, 32'h78, 1'b0);
    chk(rx_valid && rx_id == 29'h02468ACF, "R8 out of order id", 64'(rx_id), 64'h02468ACF);
    chk(rx_data == 64'h5A, "R8 single data byte", rx_data, 64'h5A);

    // R10: writes while held are ignored
    hw(4'd5, 32'hEE, 1'b0);
    hw(4'd0, 32'h02, 1'b0);
    chk(rx_valid && rx_data == 64'h5A && rx_ext, "R10 held frame unchanged", rx_data, 64'h5A);

    // R9: release with a same-cycle write starts the next frame
    hw(4'd0, 32'h42, 1'b1);
    chk(!rx_valid, "R9 not valid after release+write", 64'(rx_valid), 64'd0);
    hw(4'd1, 32'h99, 1'b0);
    hw(4'd2, 32'hE0, 1'b0);
    chk(rx_valid && rx_rtr && rx_dlc == 4'd2 && rx_id == 29'h4CF, "R9 write kept with release",
        64'(rx_id), 64'h4CF);
    release_frame();

    // R7: receive clamp with length code 15
    hw(4'd0, 32'h0F, 1'b0);
    hw(4'd1, 32'h01, 1'b0);
    hw(4'd2, 32'h20, 1'b0);
    for (int s = 3; s < 11; s++) hw(4'(s), 32'(s * 17), 1'b0);
    chk(rx_valid && rx_dlc == 4'hF, "R7 valid with 8 data slots", 64'(rx_dlc), 64'hF);
    chk(rx_data == 64'hAA99887766554433, "R7 rx data clamp", rx_data, 64'hAA99887766554433);
    release_frame();

    // R11: reset mode
    @(negedge clk);
    reset_mode = 1'b1;
    hw(4'd0, 32'h12345678, 1'b0);
    hw(4'd1, 32'h0F0F0F0F, 1'b0);
    hw(4'd2, 32'h000000E0, 1'b0);
    chk(acc_code == 32'h12345678, "R11 acc_code load", 64'(acc_code), 64'h12345678);
    chk(acc_mask == 32'h0F0F0F0F, "R11 acc_mask load", 64'(acc_mask), 64'h0F0F0F0F);
    @(negedge clk);
    tx_start = 1'b1;
    @(negedge clk);
    tx_start = 1'b0;
    @(negedge clk);
    chk(!wr_en, "R11 tx_start ignored in reset mode", 64'(wr_en), 64'd0);
    reset_mode = 1'b0;
    hw(4'd1, 32'h00, 1'b0);
    hw(4'd0, 32'h00, 1'b0);
    chk(!rx_valid, "R11 reset-mode write did not reach buffer", 64'(rx_valid), 64'd0);
    chk(acc_code == 32'h12345678 && acc_mask == 32'h0F0F0F0F, "R11 acc hold outside reset mode",
        64'(acc_code), 64'h12345678);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule